// File: doc/BRIEF.md
# ModRM/SIB Effective Address Generator

This block turns an operand-addressing byte into a memory offset. A consumer hands it the addressing byte together with the current address size, 16-bit or 32-bit. The block then pulls any scaled-index byte and any displacement bytes it needs from a separate byte stream. It adds up the selected general registers and the displacement under the rules of the chosen address size. It then reports the offset, whether the stack segment should be the default segment, and how many trailing bytes it consumed.

General registers come in as a flat, read-only snapshot. Register `i` occupies bits `[32*i+31:32*i]`, in the order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI. The 16-bit forms use the low halves: BX, BP, SI and DI are the low 16 bits of registers 3, 5, 6 and 7. The snapshot must stay stable from the time the addressing byte is accepted until the result pulse. Segment-override resolution, opcode decoding and the memory access itself are left to neighbouring logic.

Top module: `eag_top`

## Requirements
- R1: The addressing byte is accepted on a clock edge where `modrmValid` and `modrmReady` are both high. `modrmReady` is high only while the block is idle. The byte splits into mode bits [7:6], register field [5:3] and r/m bits [2:0]. The register field is presented on `eaRegField` with the result.
- R2: In 16-bit mode the r/m value selects the register sum: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX.
- R3: In 16-bit mode the offset is the register sum plus the displacement, truncated to 16 bits. Bits 31:16 of `eaOffset` are zero.
- R4: Mode 1 takes one displacement byte and sign-extends it. Mode 2 takes two bytes in 16-bit mode and four in 32-bit mode. Displacement bytes arrive least significant first. A stream byte is taken on an edge where `byteValid` and `byteReady` are both high, and idle stream cycles stall the block.
- R5: In 16-bit mode, mode 0 with r/m 6 uses a direct 16-bit displacement with no register.
- R6: In 32-bit mode with r/m other than 4, the offset is the named register plus the displacement, wrapping at 32 bits. Mode 0 with r/m 5 is instead a direct 32-bit displacement with no register.
- R7: In 32-bit mode with a mode below 3 and r/m 4, the next stream byte is a scaled-index byte, taken before any displacement. Its base field is bits [2:0], its index field bits [5:3] and its scale exponent bits [7:6]. The offset is base + (index << scale) + displacement.
- R8: A scaled-index byte whose index field is 4 adds no index term.
- R9: A scaled-index base field of 5 means a 32-bit displacement with no base register when the mode is 0. With mode 1 or 2 it means EBP.
- R10: `eaStack` is high exactly when the base register of the form is BP, EBP or ESP. Every other form, including the direct-displacement forms, reports low.
- R11: `eaBytes` equals the number of scaled-index and displacement bytes consumed. The addressing byte itself is not counted.
- R12: `eaValid` is a single-cycle pulse, one per accepted addressing byte. It rises in the cycle after the last needed byte is accepted, or in the cycle after the addressing byte if no other bytes are needed. No new addressing byte is accepted until the pulse has occurred.
- R13: An addressing byte with mode 3 consumes no stream bytes. It produces a pulse with offset 0, `eaStack` low and `eaBytes` 0.
- R14: While and after reset, `modrmReady` is high and both `byteReady` and `eaValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modrmValid | input | 1 | Addressing byte offered |
| modrmByte | input | 8 | Addressing byte |
| addr32 | input | 1 | 1 selects 32-bit address size, 0 selects 16-bit |
| modrmReady | output | 1 | Block idle and able to take an addressing byte |
| byteValid | input | 1 | Stream byte offered |
| byteData | input | 8 | Scaled-index or displacement byte |
| byteReady | output | 1 | Block waiting for a stream byte |
| gprFlat | input | 256 | Register snapshot, register i at bits [32*i+31:32*i] |
| eaValid | output | 1 | Result pulse |
| eaOffset | output | 32 | Effective offset |
| eaStack | output | 1 | Stack segment is the default segment |
| eaBytes | output | 3 | Stream bytes consumed |
| eaRegField | output | 3 | Register field of the addressing byte |

## Verification
A wrong sequencing state in this block shows up in the stream handshake. The block takes the wrong number of bytes, or takes them in the wrong order. The result pulse then arrives early or late and `eaBytes` disagrees with the form, and both are visible in the very transaction where the fault happens. A wrong latched field or register selection does not show in the handshake timing. It only appears as a wrong `eaOffset` or `eaStack` at the result pulse. For that reason each form is driven with distinct register values, sign-bit displacements and 16-bit carry-out cases. Idle gaps in the byte stream expose any counter that advances without a handshake.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int REG_W      = 32;
  localparam int NUM_GPR    = 8;
  localparam int GPR_IDX_W  = $clog2(NUM_GPR);
  localparam int BYTE_W     = 8;
  localparam int DISP_MAX   = REG_W / BYTE_W;
  localparam int CNT_W      = $clog2(DISP_MAX + 2);
  localparam int DIDX_W     = $clog2(DISP_MAX);
  localparam int HALF_W     = 16;

  // register numbers used by the addressing rules
  localparam logic [GPR_IDX_W-1:0] GPR_BX = 3'd3;
  localparam logic [GPR_IDX_W-1:0] GPR_SP = 3'd4;
  localparam logic [GPR_IDX_W-1:0] GPR_BP = 3'd5;
  localparam logic [GPR_IDX_W-1:0] GPR_SI = 3'd6;
  localparam logic [GPR_IDX_W-1:0] GPR_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SIB,
    ST_DISP,
    ST_DONE
  } eagState_t;

  typedef struct packed {
    logic              loadModrm;
    logic              loadSib;
    logic              loadDisp;
    logic [DIDX_W-1:0] dispIdx;
    logic              present;
  } eagStrobe_t;

  // Displacement length in bytes. In 32-bit mode the same rule serves the
  // r/m field and the base field of a scaled-index byte.
  function automatic logic [CNT_W-1:0] dispBytes(input logic m32,
                                                 input logic [1:0] md,
                                                 input logic [2:0] sel);
    logic [CNT_W-1:0] n;
    n = '0;
    unique case (md)
      2'd0: begin
        if (m32 && sel == 3'd5)  n = CNT_W'(DISP_MAX);
        if (!m32 && sel == 3'd6) n = CNT_W'(2);
      end
      2'd1: n = CNT_W'(1);
      2'd2: n = m32 ? CNT_W'(DISP_MAX) : CNT_W'(2);
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modrmValid,
  input  logic [1:0]       modIn,
  input  logic [2:0]       rmIn,
  input  logic             addr32,
  input  logic             byteValid,
  input  logic [2:0]       sibBaseIn,
  output logic             modrmReady,
  output logic             byteReady,
  output logic             eaValid,
  output logic [CNT_W-1:0] byteCount,
  output eagStrobe_t       strobes
);

  eagState_t        state, stateNext;
  logic [1:0]       modQ;
  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] cntQ;
  logic             sibSeenQ;

  logic             acceptM, acceptB, wantSib;
  logic [CNT_W-1:0] lenModrm, lenSib;

  always_comb begin
    modrmReady = (state == ST_IDLE);
    byteReady  = (state == ST_SIB) || (state == ST_DISP);
    eaValid    = (state == ST_DONE);
    acceptM    = modrmValid && modrmReady;
    acceptB    = byteValid && byteReady;
    wantSib    = addr32 && (modIn != 2'd3) && (rmIn == 3'd4);
    lenModrm   = dispBytes(addr32, modIn, rmIn);
    lenSib     = dispBytes(1'b1, modQ, sibBaseIn);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (acceptM) begin
        if (wantSib)               stateNext = ST_SIB;
        else if (lenModrm != '0)   stateNext = ST_DISP;
        else                       stateNext = ST_DONE;
      end
      ST_SIB: if (acceptB) begin
        stateNext = (lenSib != '0) ? ST_DISP : ST_DONE;
      end
      ST_DISP: if (acceptB && (cntQ == lenQ - CNT_W'(1))) stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modQ     <= '0;
      lenQ     <= '0;
      cntQ     <= '0;
      sibSeenQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (acceptM) begin
        modQ     <= modIn;
        sibSeenQ <= wantSib;
        lenQ     <= wantSib ? '0 : lenModrm;
        cntQ     <= '0;
      end else if (acceptB && state == ST_SIB) begin
        lenQ <= lenSib;
        cntQ <= '0;
      end else if (acceptB && state == ST_DISP) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign byteCount         = lenQ + CNT_W'(sibSeenQ);
  assign strobes.loadModrm = acceptM;
  assign strobes.loadSib   = acceptB && (state == ST_SIB);
  assign strobes.loadDisp  = acceptB && (state == ST_DISP);
  assign strobes.dispIdx   = cntQ[DIDX_W-1:0];
  assign strobes.present   = eaValid;

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> !eaValid);
  p_ready_after_r12: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |=> modrmReady);
  p_disp_cnt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISP) |-> (cntQ < lenQ));
  p_count_max_r11: assert property (@(posedge clk) disable iff (!rstN)
    eaValid |-> (byteCount <= CNT_W'(DISP_MAX + 1)));

endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  eagStrobe_t               strobes,
  input  logic [BYTE_W-1:0]        modrmByte,
  input  logic                     addr32,
  input  logic [BYTE_W-1:0]        byteData,
  input  logic [NUM_GPR*REG_W-1:0] gprFlat,
  output logic [REG_W-1:0]         eaOffset,
  output logic                     eaStack,
  output logic [2:0]               eaRegField
);

  logic [BYTE_W-1:0] modrmQ;
  logic              m32Q;
  logic [BYTE_W-1:0] sibQ;
  logic [REG_W-1:0]  dispQ;

  logic [REG_W-1:0] gpr [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
    assign gpr[g] = gprFlat[g*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modrmQ <= '0;
      m32Q   <= 1'b0;
      sibQ   <= '0;
      dispQ  <= '0;
    end else begin
      if (strobes.loadModrm) begin
        modrmQ <= modrmByte;
        m32Q   <= addr32;
        sibQ   <= '0;
        dispQ  <= '0;
      end
      if (strobes.loadSib) sibQ <= byteData;
      if (strobes.loadDisp) dispQ[strobes.dispIdx*BYTE_W +: BYTE_W] <= byteData;
    end
  end

  logic [1:0] md;
  logic [2:0] rm, sBase, sIdx;
  logic [1:0] sScale;
  assign md     = modrmQ[7:6];
  assign rm     = modrmQ[2:0];
  assign sBase  = sibQ[2:0];
  assign sIdx   = sibQ[5:3];
  assign sScale = sibQ[7:6];

  logic [REG_W-1:0] dispExt;
  assign dispExt = (md == 2'd1) ? {{(REG_W-BYTE_W){dispQ[BYTE_W-1]}}, dispQ[BYTE_W-1:0]}
                                : dispQ;

  // 16-bit table
  logic [HALF_W-1:0] termA16, termB16, off16;
  logic              stack16;
  always_comb begin
    termA16 = '0;
    termB16 = '0;
    stack16 = 1'b0;
    unique case (rm)
      3'd0: begin termA16 = gpr[GPR_BX][HALF_W-1:0]; termB16 = gpr[GPR_SI][HALF_W-1:0]; end
      3'd1: begin termA16 = gpr[GPR_BX][HALF_W-1:0]; termB16 = gpr[GPR_DI][HALF_W-1:0]; end
      3'd2: begin termA16 = gpr[GPR_BP][HALF_W-1:0]; termB16 = gpr[GPR_SI][HALF_W-1:0]; stack16 = 1'b1; end
      3'd3: begin termA16 = gpr[GPR_BP][HALF_W-1:0]; termB16 = gpr[GPR_DI][HALF_W-1:0]; stack16 = 1'b1; end
      3'd4: termA16 = gpr[GPR_SI][HALF_W-1:0];
      3'd5: termA16 = gpr[GPR_DI][HALF_W-1:0];
      3'd6: if (md != 2'd0) begin termA16 = gpr[GPR_BP][HALF_W-1:0]; stack16 = 1'b1; end
      default: termA16 = gpr[GPR_BX][HALF_W-1:0];
    endcase
    off16 = termA16 + termB16 + dispExt[HALF_W-1:0];
  end

  // 32-bit forms, with and without scaled index
  logic [REG_W-1:0] base32, idxScaled, off32;
  logic             stack32;
  always_comb begin
    base32    = '0;
    idxScaled = '0;
    stack32   = 1'b0;
    if (rm == 3'd4) begin
      if (!(md == 2'd0 && sBase == 3'd5)) begin
        base32  = gpr[sBase];
        stack32 = (sBase == GPR_SP) || (sBase == GPR_BP);
      end
      if (sIdx != 3'd4) idxScaled = gpr[sIdx] << sScale;
    end else if (!(md == 2'd0 && rm == 3'd5)) begin
      base32  = gpr[rm];
      stack32 = (rm == GPR_BP);
    end
    off32 = base32 + idxScaled + dispExt;
  end

  always_comb begin
    eaOffset   = '0;
    eaStack    = 1'b0;
    eaRegField = '0;
    if (strobes.present) begin
      eaRegField = modrmQ[5:3];
      if (md != 2'd3) begin
        eaOffset = m32Q ? off32 : {{(REG_W-HALF_W){1'b0}}, off16};
        eaStack  = m32Q ? stack32 : stack16;
      end
    end
  end

  p_wrap16_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.present && !m32Q) |-> (eaOffset[REG_W-1:HALF_W] == '0));
  p_direct16_ds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.present && !m32Q && md == 2'd0 && rm == 3'd6) |-> !eaStack);
  p_mod3_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.present && md == 2'd3) |-> (eaOffset == '0 && !eaStack));
  p_sib_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadModrm && !strobes.loadSib) |=> $stable(sibQ));

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modrmValid,
  input  logic [7:0]  modrmByte,
  input  logic        addr32,
  output logic        modrmReady,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        byteReady,
  input  logic [255:0] gprFlat,
  output logic        eaValid,
  output logic [31:0] eaOffset,
  output logic        eaStack,
  output logic [2:0]  eaBytes,
  output logic [2:0]  eaRegField
);

  eagStrobe_t       strobes;
  logic [CNT_W-1:0] byteCount;

  eag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modrmValid (modrmValid),
    .modIn      (modrmByte[7:6]),
    .rmIn       (modrmByte[2:0]),
    .addr32     (addr32),
    .byteValid  (byteValid),
    .sibBaseIn  (byteData[2:0]),
    .modrmReady (modrmReady),
    .byteReady  (byteReady),
    .eaValid    (eaValid),
    .byteCount  (byteCount),
    .strobes    (strobes)
  );

  eag_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modrmByte  (modrmByte),
    .addr32     (addr32),
    .byteData   (byteData),
    .gprFlat    (gprFlat),
    .eaOffset   (eaOffset),
    .eaStack    (eaStack),
    .eaRegField (eaRegField)
  );

  assign eaBytes = eaValid ? byteCount : '0;

endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         modrmValid = 1'b0;
  logic [7:0]   modrmByte = '0;
  logic         addr32 = 1'b0;
  logic         modrmReady;
  logic         byteValid = 1'b0;
  logic [7:0]   byteData = '0;
  logic         byteReady;
  logic [255:0] gprFlat;
  logic         eaValid;
  logic [31:0]  eaOffset;
  logic         eaStack;
  logic [2:0]   eaBytes;
  logic [2:0]   eaRegField;

  always #10 clk = ~clk;

  eag_top dut (.*);

  typedef struct {
    logic [31:0] offset;
    logic        stack;
    logic [2:0]  bytes;
    logic [2:0]  regf;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          errCnt = 0;
  int          chkCnt = 0;
  int          results = 0;
  int          sent = 0;
  logic [31:0] regs [8];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(input bit m32, input logic [7:0] mrm, input logic [7:0] sib);
    logic [1:0] md = mrm[7:6];
    logic [2:0] rm = mrm[2:0];
    if (md == 2'd3) return 0;
    if (md == 2'd1) return 1;
    if (md == 2'd2) return m32 ? 4 : 2;
    if (!m32) return (rm == 3'd6) ? 2 : 0;
    if (rm == 3'd5) return 4;
    if (rm == 3'd4 && sib[2:0] == 3'd5) return 4;
    return 0;
  endfunction

  function automatic expItem_t model(input bit m32, input logic [7:0] mrm,
                                     input logic [7:0] sib, input logic [31:0] disp,
                                     input string tag);
    expItem_t e;
    logic [1:0]  md = mrm[7:6];
    logic [2:0]  rm = mrm[2:0];
    int          n  = lenOf(m32, mrm, sib);
    logic [31:0] d, b, ix;
    logic [15:0] bx = regs[3][15:0], bp = regs[5][15:0];
    logic [15:0] si = regs[6][15:0], di = regs[7][15:0], s16;
    bit          hasSib = m32 && md != 2'd3 && rm == 3'd4;
    e.tag = tag; e.regf = mrm[5:3]; e.offset = '0; e.stack = 1'b0;
    e.bytes = 3'(n + (hasSib ? 1 : 0));
    d = (n == 0) ? 32'd0 : (n == 1) ? {{24{disp[7]}}, disp[7:0]} :
        (n == 2) ? {16'd0, disp[15:0]} : disp;
    if (md == 2'd3) return e;
    if (!m32) begin
      case (rm)
        3'd0: s16 = bx + si;
        3'd1: s16 = bx + di;
        3'd2: s16 = bp + si;
        3'd3: s16 = bp + di;
        3'd4: s16 = si;
        3'd5: s16 = di;
        3'd6: s16 = (md == 2'd0) ? 16'd0 : bp;
        default: s16 = bx;
      endcase
      e.stack  = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
      s16      = s16 + d[15:0];
      e.offset = {16'd0, s16};
    end else if (hasSib) begin
      b  = (sib[2:0] == 3'd5 && md == 2'd0) ? 32'd0 : regs[sib[2:0]];
      ix = (sib[5:3] == 3'd4) ? 32'd0 : (regs[sib[5:3]] << sib[7:6]);
      e.stack  = (sib[2:0] == 3'd4) || (sib[2:0] == 3'd5 && md != 2'd0);
      e.offset = b + ix + d;
    end else begin
      b = (rm == 3'd5 && md == 2'd0) ? 32'd0 : regs[rm];
      e.stack  = (rm == 3'd5 && md != 2'd0);
      e.offset = b + d;
    end
    return e;
  endfunction

  task automatic sendByte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    while (!byteReady) @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic xfer(input bit m32, input logic [7:0] mrm, input logic [7:0] sib,
                      input logic [31:0] disp, input int gap, input string tag);
    int n = lenOf(m32, mrm, sib);
    expQ.push_back(model(m32, mrm, sib, disp, tag));
    sent++;
    @(negedge clk);
    while (!modrmReady) @(negedge clk);
    modrmValid = 1'b1;
    modrmByte  = mrm;
    addr32     = m32;
    @(negedge clk);
    modrmValid = 1'b0;
    if (m32 && mrm[7:6] != 2'd3 && mrm[2:0] == 3'd4) sendByte(sib, gap);
    for (int i = 0; i < n; i++) sendByte(disp[i*8 +: 8], gap);
  endtask

  // monitor
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN && eaValid) begin
        results++;
        check(modrmReady == 1'b0, "R12", "modrmReady during pulse", modrmReady, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R12", "unexpected result pulse", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(eaOffset == e.offset, e.tag, "offset", eaOffset, e.offset);
          check(eaStack == e.stack, e.tag, "stack flag R10", eaStack, e.stack);
          check(eaBytes == e.bytes, e.tag, "byte count R11", eaBytes, e.bytes);
          check(eaRegField == e.regf, e.tag, "reg field R1", eaRegField, e.regf);
        end
        @(negedge clk);
        check(eaValid == 1'b0, "R12", "pulse longer than one cycle", eaValid, 0);
      end
    end
  end

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "R12", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    regs[0] = 32'h1122_3344; regs[1] = 32'h0000_1000;
    regs[2] = 32'h0000_0200; regs[3] = 32'h0000_FFF0;
    regs[4] = 32'h7FFF_0000; regs[5] = 32'h0000_8000;
    regs[6] = 32'h0000_0020; regs[7] = 32'h0000_0004;
    for (int i = 0; i < 8; i++) gprFlat[i*32 +: 32] = regs[i];

    repeat (3) @(negedge clk);
    check(modrmReady == 1'b1, "R14", "ready in reset", modrmReady, 1);
    check(byteReady == 1'b0 && eaValid == 1'b0, "R14", "idle outputs in reset",
          {byteReady, eaValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(modrmReady == 1'b1 && byteReady == 1'b0 && eaValid == 1'b0, "R14",
          "after reset", {modrmReady, byteReady, eaValid}, 3'b100);

    // 16-bit forms
    xfer(0, 8'b00_010_000, 8'h00, 32'h0, 0, "R2_R3 bx+si wrap");
    xfer(0, 8'b00_001_011, 8'h00, 32'h0, 0, "R2_R10 bp+di");
    xfer(0, 8'b00_000_110, 8'h00, 32'h1234, 1, "R5 direct16");
    xfer(0, 8'b01_011_010, 8'h00, 32'h80, 0, "R4_R10 bp+si-128");
    xfer(0, 8'b10_000_110, 8'h00, 32'hABCD, 2, "R4_R3 bp+disp16");
    xfer(0, 8'b01_111_111, 8'h00, 32'h7F, 0, "R4 bx+127");
    xfer(0, 8'b10_000_101, 8'h00, 32'hFFFE, 0, "R3 di wrap");
    // 32-bit forms
    xfer(1, 8'b00_000_000, 8'h00, 32'h0, 0, "R6 eax");
    xfer(1, 8'b00_101_101, 8'h00, 32'hDEAD_BEEF, 1, "R6 direct32");
    xfer(1, 8'b01_000_101, 8'h00, 32'hF0, 0, "R6_R10 ebp-16");
    xfer(1, 8'b10_110_011, 8'h00, 32'hFFFF_0001, 0, "R6 ebx+disp32");
    xfer(1, 8'b00_000_100, 8'b10_001_000, 32'h0, 1, "R7 eax+ecx*4");
    xfer(1, 8'b01_000_100, 8'b11_100_010, 32'h10, 0, "R8 no index");
    xfer(1, 8'b00_000_100, 8'b00_110_101, 32'h0000_5000, 2, "R9 sib direct32");
    xfer(1, 8'b01_000_100, 8'b01_111_101, 32'hFF, 0, "R9_R10 sib ebp");
    xfer(1, 8'b10_000_100, 8'b00_100_100, 32'h0000_0100, 1, "R7_R10 sib esp");
    // register-direct form
    xfer(0, 8'b11_010_001, 8'h00, 32'h0, 0, "R13 mod3");
    xfer(1, 8'b11_001_100, 8'h00, 32'h0, 0, "R13 mod3 rm4");

    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R12", "results outstanding", expQ.size(), 0);
    check(results == sent, "R12", "one pulse per byte", results, sent);
    summary();
    $finish;
  end

endmodule